// File: doc/BRIEF.md
# Reset Configuration Word Loader

This block builds the 64-bit configuration word that a device needs before it leaves reset. A 3-bit source code is read once, on the first clock after the internal reset release. That code picks how the word is gathered. In the multiplexed method, the loader walks four active-low lane selects in turn. Board logic answers each select by placing one 16-bit quarter of the word on a shared input bus. In the reduced method, a single 16-bit field is taken from the same bus, and every other bit keeps a hard-wired default. No serial memory is needed for either method.

A code that selects neither method does not stall the device. The loader publishes the default word and raises an error flag. When the word is complete, a valid flag rises. One cycle later the ready output releases the rest of the chip. Both stay high until the next reset. The asynchronous reset input is released to the logic through a two-stage synchronizer.

Top module: `rcw_loader`

## Requirements
- R1: Source code 000 loads the word in four passes. The pass on lane k writes `cfg_pins` into word bits [63-16k : 48-16k], so lane 0 fills bits 63:48 and lane 3 fills bits 15:0.
- R2: In multiplexed loading, `lane_sel_n[k]` low selects lane k. At most one bit is low at a time. The lanes are selected in the order 0, 1, 2, 3, and all bits are high once the word is valid.
- R3: Each lane stays selected for exactly S cycles, where S is `settle_cycles`, or 1 when `settle_cycles` is 0. The bus is sampled in the last of those cycles only.
- R4: Source code 011 loads the word in reduced mode. After S cycles, `cfg_pins` is written into bits [RED_LSB+15 : RED_LSB], every other bit equals DEFAULT_WORD, and no lane select goes low.
- R5: Any other source code gives exactly DEFAULT_WORD with `src_err` high and no lane selected. Codes 000 and 011 leave `src_err` low.
- R6: `rcw_valid` rises on the cycle after the final capture, together with the finished word, and stays high until reset.
- R7: `ready` rises one cycle after `rcw_valid` and stays high until reset. It is never high while `rcw_valid` is low.
- R8: The source code is sampled once, on the first clock after the internal reset release. Later changes to `src_code` do not alter the loading method or the word.
- R9: While reset is held, all lane selects are high and `rcw_valid`, `ready` and `src_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_code | input | 3 | Word source selector (000 multiplexed, 011 reduced) |
| settle_cycles | input | SETTLE_W | Cycles each pass waits before sampling (0 treated as 1) |
| cfg_pins | input | 16 | External configuration bus |
| lane_sel_n | output | 4 | Active-low lane selects, one per quarter of the word |
| rcw_word | output | 64 | Assembled configuration word |
| rcw_valid | output | 1 | Word complete, sticky until reset |
| ready | output | 1 | Release to the rest of the device, one cycle after valid |
| src_err | output | 1 | Unsupported source code was sampled |

## Verification
The bench builds the loader with SETTLE_W = 4, so the largest settle count, 15, takes only a few dozen cycles, and the bench also covers the zero-means-one case. RED_LSB = 24 places the reduced field across a lane boundary, which shows that the reduced path does not reuse the lane slicing. A non-trivial DEFAULT_WORD makes the default bits visible in the reduced and error results. The bench drives a wrong value on the bus during every settle cycle except the last, so a design that samples early produces a mismatch.

// File: rtl/rcw_pkg.sv
package rcw_pkg;

  typedef enum logic [1:0] {
    ST_SAMPLE = 2'd0,
    ST_MUX    = 2'd1,
    ST_RED    = 2'd2,
    ST_DONE   = 2'd3
  } rcw_state_e;

  localparam logic [2:0] SRC_MUX = 3'b000;
  localparam logic [2:0] SRC_RED = 3'b011;

endpackage

// File: rtl/rcw_rst_sync.sv
module rcw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/rcw_ctrl.sv
module rcw_ctrl
  import rcw_pkg::*;
#(
  parameter int N_LANES  = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          src_code,
  input  logic [SETTLE_W-1:0] settle,
  output logic [N_LANES-1:0]  lane_sel_n,
  output logic [N_LANES-1:0]  cap_lane,
  output logic                cap_red,
  output logic                done,
  output logic                bad_src
);

  localparam int LANE_IW = (N_LANES > 1) ? $clog2(N_LANES) : 1;
  localparam logic [LANE_IW-1:0] LAST_LANE = LANE_IW'(N_LANES - 1);

  rcw_state_e          state_q, state_d;
  logic [LANE_IW-1:0]  lane_q, lane_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic [SETTLE_W-1:0] limit;
  logic                last_tick;

  assign limit     = (settle == '0) ? SETTLE_W'(1) : settle;
  assign last_tick = (cnt_q == (limit - SETTLE_W'(1)));

  always_comb begin
    state_d = state_q;
    lane_d  = lane_q;
    cnt_d   = cnt_q;
    cap_red = 1'b0;
    done    = 1'b0;
    bad_src = 1'b0;
    unique case (state_q)
      ST_SAMPLE: begin
        cnt_d  = '0;
        lane_d = '0;
        if (src_code == SRC_MUX) begin
          state_d = ST_MUX;
        end else if (src_code == SRC_RED) begin
          state_d = ST_RED;
        end else begin
          state_d = ST_DONE;
          bad_src = 1'b1;
          done    = 1'b1;
        end
      end
      ST_MUX: begin
        if (last_tick) begin
          cnt_d = '0;
          if (lane_q == LAST_LANE) begin
            state_d = ST_DONE;
            done    = 1'b1;
          end else begin
            lane_d = lane_q + LANE_IW'(1);
          end
        end else begin
          cnt_d = cnt_q + SETTLE_W'(1);
        end
      end
      ST_RED: begin
        if (last_tick) begin
          cap_red = 1'b1;
          done    = 1'b1;
          state_d = ST_DONE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + SETTLE_W'(1);
        end
      end
      default: begin
        state_d = ST_DONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SAMPLE;
      lane_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
      cnt_q   <= cnt_d;
    end
  end

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    logic on_lane;
    assign on_lane       = (state_q == ST_MUX) && (lane_q == LANE_IW'(k));
    assign lane_sel_n[k] = ~on_lane;
    assign cap_lane[k]   = on_lane && last_tick;
  end

  AST_SRC_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_SAMPLE) |=> (state_q != ST_SAMPLE)); // R8
  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MUX || state_q == ST_RED) |-> (cnt_q < limit)); // R3
  AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~lane_sel_n)); // R2
  AST_LANE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MUX && !last_tick) |=> $stable(lane_sel_n)); // R3

endmodule

// File: rtl/rcw_assemble.sv
module rcw_assemble #(
  parameter int              WORD_W       = 64,
  parameter int              LANE_W       = 16,
  parameter int              N_LANES      = 4,
  parameter int              RED_LSB      = 32,
  parameter logic [WORD_W-1:0] DEFAULT_WORD = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANE_W-1:0]  pins,
  input  logic [N_LANES-1:0] cap_lane,
  input  logic               cap_red,
  output logic [WORD_W-1:0]  word_o
);

  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    for (int k = 0; k < N_LANES; k++) begin
      if (cap_lane[k]) begin
        word_d[WORD_W-1-k*LANE_W -: LANE_W] = pins;
      end
    end
    if (cap_red) begin
      word_d[RED_LSB +: LANE_W] = pins;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= DEFAULT_WORD;
    end else if ((|cap_lane) || cap_red) begin
      word_q <= word_d;
    end
  end

  assign word_o = word_q;

  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_lane, cap_red})); // R1

endmodule

// File: rtl/rcw_loader.sv
module rcw_loader
  import rcw_pkg::*;
#(
  parameter int                WORD_W       = 64,
  parameter int                LANE_W       = 16,
  parameter int                SETTLE_W     = 8,
  parameter int                RED_LSB      = 32,
  parameter logic [WORD_W-1:0] DEFAULT_WORD = 64'h0F00_4A21_0000_8C13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2:0]                   src_code,
  input  logic [SETTLE_W-1:0]          settle_cycles,
  input  logic [LANE_W-1:0]            cfg_pins,
  output logic [(WORD_W/LANE_W)-1:0]   lane_sel_n,
  output logic [WORD_W-1:0]            rcw_word,
  output logic                         rcw_valid,
  output logic                         ready,
  output logic                         src_err
);

  localparam int N_LANES = WORD_W / LANE_W;

  logic               rst_int_n;
  logic [N_LANES-1:0] cap_lane;
  logic               cap_red, done, bad_src;
  logic               valid_q, valid_d, ready_q, ready_d, err_q, err_d;

  rcw_rst_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  rcw_ctrl #(.N_LANES(N_LANES), .SETTLE_W(SETTLE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .src_code   (src_code),
    .settle     (settle_cycles),
    .lane_sel_n (lane_sel_n),
    .cap_lane   (cap_lane),
    .cap_red    (cap_red),
    .done       (done),
    .bad_src    (bad_src)
  );

  rcw_assemble #(
    .WORD_W(WORD_W), .LANE_W(LANE_W), .N_LANES(N_LANES),
    .RED_LSB(RED_LSB), .DEFAULT_WORD(DEFAULT_WORD)
  ) u_asm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pins     (cfg_pins),
    .cap_lane (cap_lane),
    .cap_red  (cap_red),
    .word_o   (rcw_word)
  );

  always_comb begin
    valid_d = valid_q | done;
    ready_d = ready_q | valid_q;
    err_d   = err_q | bad_src;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ready_q <= ready_d;
      err_q   <= err_d;
    end
  end

  assign rcw_valid = valid_q;
  assign ready     = ready_q;
  assign src_err   = err_q;

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    rcw_valid |=> rcw_valid); // R6
  AST_READY_LAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rcw_valid) |=> ready); // R7
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_int_n)
    ready |-> rcw_valid); // R7
  AST_LANES_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    rcw_valid |-> (&lane_sel_n)); // R2
  AST_ERR_DEFAULT: assert property (@(posedge clk) disable iff (!rst_int_n)
    src_err |-> (rcw_word == DEFAULT_WORD && (&lane_sel_n))); // R5

endmodule

// File: tb/sim_rcw_loader.sv
`timescale 1ns/1ps
module sim_rcw_loader;

  localparam int          SW   = 4;
  localparam int          RLSB = 24;
  localparam logic [63:0] DFLT = 64'hA5C3_0F1E_7788_9966;

  typedef struct { logic [63:0] word; logic err; logic mux; } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    src_code;
  logic [SW-1:0] settle;
  logic [15:0]   pins;
  logic [3:0]    lane_sel_n;
  logic [63:0]   rcw_word;
  logic          rcw_valid, ready, src_err;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  exp_t sb_q[$];

  logic [63:0] cur_data;
  logic [15:0] red_pins;
  int          cur_s;
  bit          cur_mux;
  int          exp_lane;

  always #4 clk = ~clk;

  rcw_loader #(.SETTLE_W(SW), .RED_LSB(RLSB), .DEFAULT_WORD(DFLT)) u0 (
    .clk(clk), .rst_n(rst_n), .src_code(src_code), .settle_cycles(settle),
    .cfg_pins(pins), .lane_sel_n(lane_sel_n), .rcw_word(rcw_word),
    .rcw_valid(rcw_valid), .ready(ready), .src_err(src_err));

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: drives the bus per lane, checks lane timing, pops the scoreboard
  logic [3:0] prev_lanes;
  int         run_len;
  bit         prev_valid, pend_ready;
  always @(negedge clk) begin
    logic [3:0] cur;
    int idx;
    cur = ~lane_sel_n;
    if (!rst_n) begin
      prev_lanes = '0; run_len = 0; prev_valid = 0; pend_ready = 0;
      pins = red_pins;
    end else begin
      if (pend_ready) begin
        chk(ready === 1'b1, "R7 ready one cycle after valid", {63'b0, ready}, 64'd1);
        pend_ready = 0;
      end
      if (rcw_valid && !prev_valid) begin
        exp_t e;
        if (sb_q.size() == 0) begin
          chk(0, "R1 unexpected valid", rcw_word, 64'd0);
        end else begin
          e = sb_q.pop_front();
          chk(rcw_word === e.word, "R1/R4/R5 word", rcw_word, e.word);
          chk(src_err === e.err, "R5 error flag", {63'b0, src_err}, {63'b0, e.err});
          if (e.mux)
            chk(prev_lanes == 4'b1000 && cur == 4'b0000,
                "R6 valid follows last capture", {60'b0, prev_lanes}, 64'h8);
        end
        chk(ready === 1'b0, "R7 ready not with valid", {63'b0, ready}, 64'd0);
        pend_ready = 1;
      end
      prev_valid = rcw_valid;
      if (cur != prev_lanes) begin
        if (prev_lanes != 0)
          chk(run_len == cur_s, "R3 lane hold cycles", 64'(run_len), 64'(cur_s));
        if (cur != 0) begin
          if (!cur_mux) chk(0, "R4/R5 lane selected outside mux mode", {60'b0, cur}, 64'd0);
          else chk(cur == (4'b1 << exp_lane), "R2 lane order", {60'b0, cur},
                   64'(4'b1 << exp_lane));
          exp_lane++;
        end
        run_len = 0;
      end
      prev_lanes = cur;
      if (cur != 0) begin
        idx = 0;
        for (int k = 0; k < 4; k++) if (cur[k]) idx = k;
        if (run_len == cur_s - 1) pins = 16'(cur_data >> (48 - 16 * idx));
        else pins = ~16'(cur_data >> (48 - 16 * idx));
        run_len++;
      end else begin
        pins = red_pins;
      end
    end
  end

  task automatic run_case(logic [2:0] src, logic [SW-1:0] st, logic [63:0] data,
                          logic [15:0] rp, bit chg_src);
    exp_t e;
    bit got;
    rst_n    = 1'b0;
    src_code = src;
    settle   = st;
    cur_data = data;
    red_pins = rp;
    cur_s    = (st == 0) ? 1 : int'(st);
    cur_mux  = (src == 3'b000);
    exp_lane = 0;
    e.mux = cur_mux;
    e.err = !(src == 3'b000 || src == 3'b011);
    if (src == 3'b000) e.word = data;
    else if (src == 3'b011) begin e.word = DFLT; e.word[RLSB +: 16] = rp; end
    else e.word = DFLT;
    sb_q.push_back(e);
    repeat (3) @(negedge clk);
    chk(lane_sel_n === 4'hF, "R9 lanes idle in reset", {60'b0, lane_sel_n}, 64'hF);
    chk({rcw_valid, ready, src_err} === 3'b000, "R9 flags low in reset",
        {61'b0, rcw_valid, ready, src_err}, 64'd0);
    rst_n = 1'b1;
    if (chg_src) begin
      repeat (5) @(negedge clk);
      src_code = ~src;  // R8: late change must be ignored
    end
    got = 0;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk);
      if (rcw_valid) got = 1;
    end
    chk(got, "R6 valid reached", {63'b0, got}, 64'd1);
    repeat (6) @(negedge clk);
    chk(rcw_valid === 1'b1 && ready === 1'b1, "R6/R7 flags sticky",
        {62'b0, rcw_valid, ready}, 64'd3);
    chk(rcw_word === e.word, "R8 word unchanged after hold", rcw_word, e.word);
    chk(sb_q.size() == 0, "R1 scoreboard drained", 64'(sb_q.size()), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; src_code = 3'b000; settle = '0; red_pins = 16'h0;
    cur_data = '0; cur_s = 1; cur_mux = 0; exp_lane = 0;
    run_case(3'b000, 4'd0,  64'h1122_3344_5566_7788, 16'h0000, 0); // R1 R3 zero settle
    run_case(3'b000, 4'd3,  64'hDEAD_BEEF_CAFE_F00D, 16'h1234, 1); // R8 late change
    run_case(3'b000, 4'd15, 64'h0000_0000_0000_0000, 16'hFFFF, 0); // R3 max settle
    run_case(3'b011, 4'd2,  64'h0,                   16'hBEEF, 0); // R4
    run_case(3'b011, 4'd0,  64'h0,                   16'h0F0F, 1); // R4 R8
    run_case(3'b001, 4'd5,  64'h0,                   16'h7777, 0); // R5 serial code
    run_case(3'b111, 4'd1,  64'h0,                   16'h0001, 0); // R5
    run_case(3'b000, 4'd7,  64'hFFFF_0001_8000_5A5A, 16'h2222, 0); // R5 err cleared
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog expired", 64'd0, 64'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule